// File: doc/BRIEF.md
# Bidirectional latched inverting transceiver

This block connects two 16-bit buses, port A and port B, through a pair of storage latches per 8-bit half: one latch carries data from A to B and the other from B to A. Each direction of each half has three active-low controls of its own: a chip select, a latch-open input and a drive enable. The value passed across is always the bitwise inverse of the captured data. The two halves share nothing, so the block can serve as one 16-bit path or as two separate 8-bit paths.

The latch is level-style but clocked. While chip select and latch-open are both low, the direction is transparent. The output follows its source port without delay, and the store reloads from that port on every rising clock edge. When either control rises, the store keeps the value it took at the last edge on which the direction was open.

A port is not a true tri-state pin here. It is an input vector, an output vector and one drive flag per half. When the drive flag is low, the output byte reads zero, so a surrounding bench or wrapper can resolve bus ownership and detect contention.

Top module: `xcvr16_top`

## Requirements
- R1: The B drive flag of a half is 1 exactly when that half's A-to-B chip select and drive enable are both low. Otherwise the flag is 0 and that byte of b_out reads 0x00.
- R2: With chip select, latch-open and drive enable all low, the B byte equals the bitwise inverse of the A byte in the same cycle, for example A=0x3C gives B=0xC3.
- R3: The store loads the source byte on every rising clock edge at which chip select and latch-open are both low. Once latch-open or chip select is high, a driven output shows the inverse of the byte loaded at the last such edge.
- R4: While a direction is not transparent, changes on its source port have no effect on its driven output.
- R5: A high chip select prevents loading even when latch-open is low.
- R6: The drive enable gates only the output. The store still loads while the drive enable is high.
- R7: The B-to-A direction behaves the same way through its own controls, b_in, a_out and a_drv.
- R8: Controls and data of one half have no effect on the outputs of the other half.
- R9: Reset clears every store to 0x00. After reset, a driven direction that is holding shows 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stores load on its rising edge |
| rst_n | input | 1 | Active-low reset, clears all stores |
| a_in | input | 16 | Data arriving on port A |
| b_in | input | 16 | Data arriving on port B |
| ab_ce_n | input | 2 | A-to-B chip select per half, active low |
| ab_le_n | input | 2 | A-to-B latch-open per half, active low |
| ab_oe_n | input | 2 | A-to-B drive enable per half, active low |
| ba_ce_n | input | 2 | B-to-A chip select per half, active low |
| ba_le_n | input | 2 | B-to-A latch-open per half, active low |
| ba_oe_n | input | 2 | B-to-A drive enable per half, active low |
| b_out | output | 16 | Inverted data driven onto port B |
| b_drv | output | 2 | Port B drive flag per half |
| a_out | output | 16 | Inverted data driven onto port A |
| a_drv | output | 2 | Port A drive flag per half |

## Verification
The hardest situation to reach is a store that has changed while nothing is visible. Loading with the drive enable high, or ending transparency by raising chip select instead of latch-open, leaves no trace on the port at the moment it happens. The stimulus therefore loads or blocks a byte while the output is gated off. It then returns to a holding, driving state, so the stored byte appears on the output and can be compared. The final check ends transparency with a chip-select rise and then changes the source, which shows that the value captured at the last open edge is the one that remains.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // direction is transparent when both active-low controls are asserted
  function automatic logic xc_open(input logic ce_n, input logic le_n);
    return !ce_n && !le_n;
  endfunction

  // port is driven when chip select and drive enable are both asserted
  function automatic logic xc_drive(input logic ce_n, input logic oe_n);
    return !ce_n && !oe_n;
  endfunction

  // visible byte: inverse of live data when open, of the store otherwise
  function automatic logic [7:0] xc_view(input logic open, input logic [7:0] live,
                                         input logic [7:0] held);
    return open ? ~live : ~held;
  endfunction
endpackage

// File: rtl/xcvr_dir.sv
module xcvr_dir
  import xcvr_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             le_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] src,
  output logic [LANES-1:0] dst,
  output logic             drv,
  output logic             open
);
  logic [LANES-1:0] held;
  logic [LANES-1:0] view;

  assign open = xc_open(ce_n, le_n);
  assign drv  = xc_drive(ce_n, oe_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held <= '0;
    else if (open) held <= src;
  end

  always_comb begin
    view = open ? ~src : ~held;
    dst  = drv ? view : '0;
  end
endmodule

// File: rtl/xcvr_half.sv
module xcvr_half #(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] a_in,
  input  logic [LANES-1:0] b_in,
  input  logic             ab_ce_n,
  input  logic             ab_le_n,
  input  logic             ab_oe_n,
  input  logic             ba_ce_n,
  input  logic             ba_le_n,
  input  logic             ba_oe_n,
  output logic [LANES-1:0] b_out,
  output logic             b_drv,
  output logic [LANES-1:0] a_out,
  output logic             a_drv,
  output logic             ab_open,
  output logic             ba_open
);
  xcvr_dir #(.LANES(LANES)) u_ab (
    .clk(clk), .rst_n(rst_n), .ce_n(ab_ce_n), .le_n(ab_le_n), .oe_n(ab_oe_n),
    .src(a_in), .dst(b_out), .drv(b_drv), .open(ab_open)
  );

  xcvr_dir #(.LANES(LANES)) u_ba (
    .clk(clk), .rst_n(rst_n), .ce_n(ba_ce_n), .le_n(ba_le_n), .oe_n(ba_oe_n),
    .src(b_in), .dst(a_out), .drv(a_drv), .open(ba_open)
  );
endmodule

// File: rtl/xcvr16_top.sv
module xcvr16_top #(
  parameter int LANES  = 8,
  parameter int HALVES = 2,
  localparam int W     = LANES * HALVES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      a_in,
  input  logic [W-1:0]      b_in,
  input  logic [HALVES-1:0] ab_ce_n,
  input  logic [HALVES-1:0] ab_le_n,
  input  logic [HALVES-1:0] ab_oe_n,
  input  logic [HALVES-1:0] ba_ce_n,
  input  logic [HALVES-1:0] ba_le_n,
  input  logic [HALVES-1:0] ba_oe_n,
  output logic [W-1:0]      b_out,
  output logic [HALVES-1:0] b_drv,
  output logic [W-1:0]      a_out,
  output logic [HALVES-1:0] a_drv
);
  // transparency events, brought out for the checker
  logic [HALVES-1:0] ab_open;
  logic [HALVES-1:0] ba_open;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    xcvr_half #(.LANES(LANES)) u_half (
      .clk(clk), .rst_n(rst_n),
      .a_in(a_in[h*LANES +: LANES]), .b_in(b_in[h*LANES +: LANES]),
      .ab_ce_n(ab_ce_n[h]), .ab_le_n(ab_le_n[h]), .ab_oe_n(ab_oe_n[h]),
      .ba_ce_n(ba_ce_n[h]), .ba_le_n(ba_le_n[h]), .ba_oe_n(ba_oe_n[h]),
      .b_out(b_out[h*LANES +: LANES]), .b_drv(b_drv[h]),
      .a_out(a_out[h*LANES +: LANES]), .a_drv(a_drv[h]),
      .ab_open(ab_open[h]), .ba_open(ba_open[h])
    );
  end
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int LANES  = 8,
  parameter int HALVES = 2,
  localparam int W     = LANES * HALVES
) (
  input logic              clk,
  input logic              rst_n,
  input logic [W-1:0]      a_in,
  input logic [W-1:0]      b_in,
  input logic [HALVES-1:0] ab_ce_n,
  input logic [HALVES-1:0] ab_oe_n,
  input logic [HALVES-1:0] ba_ce_n,
  input logic [HALVES-1:0] ba_oe_n,
  input logic [W-1:0]      b_out,
  input logic [HALVES-1:0] b_drv,
  input logic [W-1:0]      a_out,
  input logic [HALVES-1:0] a_drv,
  input logic [HALVES-1:0] ab_open,
  input logic [HALVES-1:0] ba_open
);
  for (genvar h = 0; h < HALVES; h++) begin : g_chk
    // R1: gated port carries no drive flag and a zero byte
    assert_gate_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ab_ce_n[h] || ab_oe_n[h]) |-> (!b_drv[h] && b_out[h*LANES +: LANES] == '0));
    // R2: transparent and driven shows inverse of live A
    assert_pass_inv_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ab_open[h] && b_drv[h]) |-> (b_out[h*LANES +: LANES] == ~a_in[h*LANES +: LANES]));
    // R3: after transparency ends the byte of the last open edge is shown
    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ab_open[h]) && !ab_open[h] && b_drv[h])
      |-> (b_out[h*LANES +: LANES] == ~$past(a_in[h*LANES +: LANES])));
    // R4: held and driven output does not move
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(!ab_open[h] && b_drv[h]) && !ab_open[h] && b_drv[h])
      |-> $stable(b_out[h*LANES +: LANES]));
    // R7: reverse direction, transparent and gated cases
    assert_rev_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ba_open[h] && a_drv[h]) |-> (a_out[h*LANES +: LANES] == ~b_in[h*LANES +: LANES]));
    assert_rev_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ba_ce_n[h] || ba_oe_n[h]) |-> (!a_drv[h] && a_out[h*LANES +: LANES] == '0));
  end
endmodule

bind xcvr16_top xcvr_chk #(.LANES(LANES), .HALVES(HALVES)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
  .ab_ce_n(ab_ce_n), .ab_oe_n(ab_oe_n), .ba_ce_n(ba_ce_n), .ba_oe_n(ba_oe_n),
  .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv),
  .ab_open(ab_open), .ba_open(ba_open)
);

// File: tb/sim_xcvr16_top.sv
`timescale 1ns/1ps
module sim_xcvr16_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a_in = '0, b_in = '0;
  logic [1:0]  ab_ce_n = 2'b11, ab_le_n = 2'b11, ab_oe_n = 2'b11;
  logic [1:0]  ba_ce_n = 2'b11, ba_le_n = 2'b11, ba_oe_n = 2'b11;
  logic [15:0] b_out, a_out;
  logic [1:0]  b_drv, a_drv;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xcvr16_top u0 (.*);

  // {ce_n, le_n, oe_n, a, exp_drv, exp_b} for half 0, A to B
  localparam logic [19:0] VEC [13] = '{
    {3'b000, 8'h3C, 1'b1, 8'hC3},  // R2 transparent
    {3'b000, 8'hA5, 1'b1, 8'h5A},  // R2 transparent, new data
    {3'b010, 8'hA5, 1'b1, 8'h5A},  // R3 latch closes on A5
    {3'b010, 8'h0F, 1'b1, 8'h5A},  // R4 source change ignored
    {3'b011, 8'h0F, 1'b0, 8'h00},  // R1 drive enable high
    {3'b100, 8'hFF, 1'b0, 8'h00},  // R1 chip select high
    {3'b010, 8'hFF, 1'b1, 8'h5A},  // R5 no load while chip select high
    {3'b001, 8'h81, 1'b0, 8'h00},  // R6 loads 81 while gated
    {3'b010, 8'h00, 1'b1, 8'h7E},  // R6 stored 81 appears
    {3'b000, 8'h00, 1'b1, 8'hFF},  // R2 transparent zero
    {3'b100, 8'h00, 1'b0, 8'h00},  // R3 chip select rise ends transparency
    {3'b100, 8'h55, 1'b0, 8'h00},  // R5 blocked
    {3'b010, 8'h55, 1'b1, 8'hFF}   // R3 byte from last open edge kept
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (3) step();
    // R1 and R9: reset state, nothing driven
    chk("R1", {b_drv, a_drv}, 4'b0000);
    chk("R1", b_out | a_out, 16'h0000);
    rst_n = 1'b1;
    step();
    // R9: cleared store shows FF when held and driven
    ab_ce_n[1] = 0; ab_le_n[1] = 1; ab_oe_n[1] = 0;
    step();
    chk("R9", b_out[15:8], 8'hFF);
    ab_ce_n[1] = 1; ab_oe_n[1] = 1;

    for (int i = 0; i < 13; i++) begin
      {ab_ce_n[0], ab_le_n[0], ab_oe_n[0]} = VEC[i][19:17];
      a_in[7:0] = VEC[i][16:9];
      step();
      chk($sformatf("R1-table vector %0d drive", i), {15'd0, b_drv[0]}, {15'd0, VEC[i][8]});
      chk($sformatf("R2 R3 R4 R5 R6 vector %0d data", i), {8'd0, b_out[7:0]}, {8'd0, VEC[i][7:0]});
    end

    // R7: B to A on half 1, transparent then held
    ba_ce_n[1] = 0; ba_le_n[1] = 0; ba_oe_n[1] = 0; b_in[15:8] = 8'h12;
    step();
    chk("R7", {a_drv[1], 7'd0, a_out[15:8]}, {1'b1, 7'd0, 8'hED});
    ba_le_n[1] = 1;
    step();
    b_in[15:8] = 8'h99;
    step();
    chk("R7", {8'd0, a_out[15:8]}, 16'h00ED);

    // R8: half 0 holding FF; half 1 churns, half 0 unchanged
    ab_ce_n[1] = 0; ab_le_n[1] = 0; ab_oe_n[1] = 0;
    a_in[15:8] = 8'hF0;
    step();
    chk("R8", {b_out[15:8], b_out[7:0]}, {8'h0F, 8'hFF});
    a_in[15:8] = 8'h11; ab_oe_n[1] = 1;
    step();
    chk("R8", {b_out[15:8], b_out[7:0]}, {8'h00, 8'hFF});
    // R8: half 1 reverse output unaffected by half 0 reverse traffic
    ba_ce_n[0] = 0; ba_le_n[0] = 0; ba_oe_n[0] = 0; b_in[7:0] = 8'h01;
    step();
    chk("R8", a_out, {8'hED, 8'hFE});

    // R9: reset mid-run clears stores
    rst_n = 0;
    step();
    rst_n = 1;
    ba_le_n[1] = 1;
    ab_ce_n[0] = 0; ab_le_n[0] = 1; ab_oe_n[0] = 0;
    step();
    chk("R9", {a_out[15:8], b_out[7:0]}, 16'hFFFF);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule